// File: doc/BRIEF.md
# Six-Stage Pipeline Hazard and Forwarding Controller

This block decides, for an in-order integer pipeline with the stages fetch, decode, execute, first memory, second memory and writeback, when the instruction in decode may advance and where each of its two execute operands should come from. It looks at the destination register, write enable and load flag of the three instructions ahead of decode (in execute, first memory and second memory). It compares them with the two source register numbers of the decode instruction. It also watches the branch-mispredict and jump indications raised in execute.

Because a memory access spans two stages, a loaded value exists only once the load has left the second memory stage. A consumer right behind a load therefore waits two cycles. A consumer with one unrelated instruction in between waits one cycle. ALU results, by contrast, are forwarded from any of the three later pipeline registers without delay. The operand selects are worked out while the consumer sits in decode and are registered, so they are stable at the start of the cycle in which that instruction executes.

The stall output freezes the program counter and the fetch/decode register. The bubble output turns the decode/execute register into a no-op with all write enables cleared. The flush output discards the one wrong-path instruction after a redirect.

Top module: `hz_fwd_ctrl`

## Requirements
- R1: While reset is high at a rising edge, both operand selects become 00 at that edge.
- R2: Select encoding is 00 register file, 01 execute/mem1 register, 10 mem1/mem2 register, 11 mem2/writeback register. A select appears on the fwd outputs in the cycle after the decode inputs that caused it.
- R3: When several producers match a source, the youngest wins: execute over mem1 over mem2. This includes a younger non-load that hides an older load to the same register.
- R4: A source of register 0, or a producer whose destination is register 0, never forwards and never stalls.
- R5: A matching load in execute or mem1 raises stall. A matching load in mem2 raises no stall and selects 11 for the next cycle.
- R6: A matching non-load in execute, mem1 or mem2 is forwarded with no stall, selecting 01, 10 or 11 respectively.
- R7: Whenever stall is high, bubble is high, and both selects are 00 in the next cycle.
- R8: A mispredict or a jump raises flush and bubble in the same cycle, and both selects are 00 in the next cycle.
- R9: When a redirect and a load-use hazard occur in the same cycle, flush is high and stall is low.
- R10: A producer whose write enable is low, or whose destination differs from the source, has no effect on stall or on the selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ex_dst | input | 5 | Destination register of the instruction in execute |
| ex_we | input | 1 | Register write enable of the instruction in execute |
| ex_ld | input | 1 | Instruction in execute is a load |
| m1_dst | input | 5 | Destination register in the first memory stage |
| m1_we | input | 1 | Register write enable in the first memory stage |
| m1_ld | input | 1 | Instruction in the first memory stage is a load |
| m2_dst | input | 5 | Destination register in the second memory stage |
| m2_we | input | 1 | Register write enable in the second memory stage |
| id_rs_a | input | 5 | First source register of the decode instruction |
| id_rs_b | input | 5 | Second source register of the decode instruction |
| ex_mispredict | input | 1 | Branch in execute was mispredicted |
| ex_jump | input | 1 | Jump in execute |
| stall | output | 1 | Hold program counter and fetch/decode register |
| bubble | output | 1 | Load a no-op into the decode/execute register |
| flush | output | 1 | Discard the wrong-path instruction |
| fwd_a | output | 2 | Execute operand A select |
| fwd_b | output | 2 | Execute operand B select |

## Verification
The two functions that can land in one cycle are the load-use stall and the redirect flush. The bench provokes this by placing a load in execute whose destination matches a decode source while also raising mispredict or jump, in directed steps and in random traffic over a four-register space. The cycle is judged against a behavioural model: flush and bubble must be high, stall must be low, and both selects must read 00 in the following cycle, because no consumer advances.

// File: rtl/hz_pkg.sv
package hz_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int REG_AW   = 5;   // register number width
    localparam int NUM_PROD = 3;   // producers visible from decode: EX, MEM1, MEM2
    localparam int LD_BLOCK = 2;   // producers closer than this that are loads cannot forward
    localparam int NUM_SRC  = 2;   // source operands per instruction

    typedef enum logic [1:0] {
        FWD_RF   = 2'd0,
        FWD_EXM1 = 2'd1,
        FWD_M1M2 = 2'd2,
        FWD_M2WB = 2'd3
    } fwd_sel_e;

    typedef logic [REG_AW-1:0] reg_t;

    typedef struct packed {
        logic we;
        logic ld;
        reg_t dst;
    } prod_t;

    function automatic logic prod_hits(prod_t p, reg_t src);
        return p.we && (p.dst == src) && (src != '0);
    endfunction
endpackage

// File: rtl/hz_src_resolve.sv
module hz_src_resolve
    import hz_pkg::*;
(
    input  prod_t    prod [NUM_PROD],
    input  reg_t     src,
    output fwd_sel_e sel,
    output logic     hold
);
    timeunit 1ns;
    timeprecision 1ps;

    // Walk oldest to youngest so the youngest match is the one left standing.
    always_comb begin
        sel  = FWD_RF;
        hold = 1'b0;
        for (int i = NUM_PROD - 1; i >= 0; i--) begin
            if (prod_hits(prod[i], src)) begin
                if (prod[i].ld && (i < LD_BLOCK)) begin
                    sel  = FWD_RF;
                    hold = 1'b1;
                end else begin
                    sel  = fwd_sel_e'(2'(i + 1));
                    hold = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hz_stall_arb.sv
module hz_stall_arb
    import hz_pkg::*;
(
    input  logic [NUM_SRC-1:0] hold,
    input  logic               mispredict,
    input  logic               jump,
    output logic               stall,
    output logic               bubble,
    output logic               flush
);
    timeunit 1ns;
    timeprecision 1ps;

    logic hazard;

    always_comb begin
        hazard = |hold;
        flush  = mispredict | jump;
        stall  = hazard & ~flush;   // the redirect wins over a stall
        bubble = hazard | flush;
    end
endmodule

// File: rtl/hz_sel_reg.sv
module hz_sel_reg
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clear,
    input  fwd_sel_e d,
    output fwd_sel_e q
);
    timeunit 1ns;
    timeprecision 1ps;

    always_ff @(posedge clk) begin
        if (rst || clear) q <= FWD_RF;
        else              q <= d;
    end
endmodule

// File: rtl/hz_fwd_ctrl.sv
module hz_fwd_ctrl
    import hz_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] ex_dst,
    input  logic              ex_we,
    input  logic              ex_ld,
    input  logic [REG_AW-1:0] m1_dst,
    input  logic              m1_we,
    input  logic              m1_ld,
    input  logic [REG_AW-1:0] m2_dst,
    input  logic              m2_we,
    input  logic [REG_AW-1:0] id_rs_a,
    input  logic [REG_AW-1:0] id_rs_b,
    input  logic              ex_mispredict,
    input  logic              ex_jump,
    output logic              stall,
    output logic              bubble,
    output logic              flush,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b
);
    timeunit 1ns;
    timeprecision 1ps;

    prod_t               prod [NUM_PROD];
    reg_t                srcs [NUM_SRC];
    fwd_sel_e            sel_d [NUM_SRC];
    fwd_sel_e            sel_q [NUM_SRC];
    logic [NUM_SRC-1:0]  hold;

    // Index 0 is the youngest producer. The mem2 result may always be
    // forwarded, so its load flag is not needed.
    always_comb begin
        prod[0] = '{we: ex_we, ld: ex_ld, dst: ex_dst};
        prod[1] = '{we: m1_we, ld: m1_ld, dst: m1_dst};
        prod[2] = '{we: m2_we, ld: 1'b0,  dst: m2_dst};
        srcs[0] = id_rs_a;
        srcs[1] = id_rs_b;
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        hz_src_resolve u_res (
            .prod (prod),
            .src  (srcs[s]),
            .sel  (sel_d[s]),
            .hold (hold[s])
        );

        hz_sel_reg u_sel (
            .clk   (clk),
            .rst   (rst),
            .clear (bubble),
            .d     (sel_d[s]),
            .q     (sel_q[s])
        );
    end

    hz_stall_arb u_arb (
        .hold       (hold),
        .mispredict (ex_mispredict),
        .jump       (ex_jump),
        .stall      (stall),
        .bubble     (bubble),
        .flush      (flush)
    );

    assign fwd_a = sel_q[0];
    assign fwd_b = sel_q[1];
endmodule

// File: rtl/hz_fwd_ctrl_chk.sv
module hz_fwd_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [4:0] ex_dst,
    input logic       ex_we,
    input logic       ex_ld,
    input logic [4:0] m1_dst,
    input logic       m1_we,
    input logic       m1_ld,
    input logic [4:0] id_rs_a,
    input logic [4:0] id_rs_b,
    input logic       ex_mispredict,
    input logic       ex_jump,
    input logic       stall,
    input logic       bubble,
    input logic       flush,
    input logic [1:0] fwd_a,
    input logic [1:0] fwd_b
);
    timeunit 1ns;
    timeprecision 1ps;

    AST_ZERO_SRC_NO_STALL: assert property (@(posedge clk) disable iff (rst)
        (id_rs_a == 5'd0 && id_rs_b == 5'd0) |-> !stall); // R4

    AST_REDIRECT_FLUSHES: assert property (@(posedge clk) disable iff (rst)
        (ex_mispredict || ex_jump) |-> (flush && bubble)); // R8

    AST_FLUSH_OVER_STALL: assert property (@(posedge clk) disable iff (rst)
        flush |-> !stall); // R9

    AST_STALL_BUBBLE: assert property (@(posedge clk) disable iff (rst)
        stall |-> bubble); // R7

    AST_BUBBLE_CLEARS_SEL: assert property (@(posedge clk) disable iff (rst)
        bubble |=> (fwd_a == 2'd0 && fwd_b == 2'd0)); // R7

    AST_EX_FWD_NOT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (fwd_a == 2'd1) |-> $past(ex_we && !ex_ld && ex_dst == id_rs_a && id_rs_a != 5'd0)); // R6

    AST_M1_FWD_NOT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (fwd_b == 2'd2) |-> $past(m1_we && !m1_ld && m1_dst == id_rs_b && id_rs_b != 5'd0)); // R6
endmodule

bind hz_fwd_ctrl hz_fwd_ctrl_chk chk_i (.*);

// File: tb/hz_fwd_ctrl_tb_top.sv
module hz_fwd_ctrl_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ex_dst = '0, m1_dst = '0, m2_dst = '0, id_rs_a = '0, id_rs_b = '0;
    logic       ex_we = 0, ex_ld = 0, m1_we = 0, m1_ld = 0, m2_we = 0;
    logic       ex_mispredict = 0, ex_jump = 0;
    logic       stall, bubble, flush;
    logic [1:0] fwd_a, fwd_b;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 8 ns period

    hz_fwd_ctrl dut_i (.*);

    // Behavioural producer table, index = distance ahead of decode.
    int pd [4];
    bit pw [4];
    bit pl [4];

    function automatic void ref_src(input int src, output int sel, output bit hold);
        sel  = 0;
        hold = 0;
        if (src != 0) begin
            for (int d = 1; d <= 3; d++) begin
                if (pw[d] && pd[d] == src) begin
                    if (pl[d] && d <= 2) hold = 1;
                    else                 sel  = d;
                    break;
                end
            end
        end
    endfunction

    task automatic cmp(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Apply one decode-cycle worth of inputs at a falling edge, let the
    // rising edge register the selects, then compare at the next falling edge.
    task automatic step(input string req,
                        input int exd, input bit exw, input bit exl,
                        input int m1d, input bit m1w, input bit m1l,
                        input int m2d, input bit m2w,
                        input int ra, input int rb, input bit mis, input bit jmp);
        int sa, sb;
        bit ha, hb, e_stall, e_bub, e_flush;
        ex_dst = 5'(exd); ex_we = exw; ex_ld = exl;
        m1_dst = 5'(m1d); m1_we = m1w; m1_ld = m1l;
        m2_dst = 5'(m2d); m2_we = m2w;
        id_rs_a = 5'(ra); id_rs_b = 5'(rb);
        ex_mispredict = mis; ex_jump = jmp;
        pd[1] = exd; pw[1] = exw; pl[1] = exl;
        pd[2] = m1d; pw[2] = m1w; pl[2] = m1l;
        pd[3] = m2d; pw[3] = m2w; pl[3] = 0;
        ref_src(ra, sa, ha);
        ref_src(rb, sb, hb);
        e_flush = mis || jmp;
        e_stall = (ha || hb) && !e_flush;
        e_bub   = ha || hb || e_flush;
        if (e_bub || rst) begin sa = 0; sb = 0; end
        @(negedge clk);
        if (!rst) begin
            cmp(req, "stall",  stall,  e_stall);
            cmp(req, "bubble", bubble, e_bub);
            cmp(req, "flush",  flush,  e_flush);
        end
        cmp(req, "fwd_a", fwd_a, sa);
        cmp(req, "fwd_b", fwd_b, sb);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: selects cleared under reset despite matching producers
        step("R1", 1,1,0, 2,1,0, 3,1, 1,2, 0,0);
        step("R1", 1,1,0, 2,1,0, 3,1, 1,2, 0,0);
        rst = 1'b0;
        // R6 / R2: non-load forwarding from each stage
        step("R6", 1,1,0, 0,0,0, 0,0, 1,0, 0,0);
        step("R6", 0,0,0, 2,1,0, 0,0, 0,2, 0,0);
        step("R2", 0,0,0, 0,0,0, 3,1, 3,3, 0,0);
        // R3: youngest match wins
        step("R3", 5,1,0, 5,1,0, 5,1, 5,5, 0,0);
        step("R3", 0,0,0, 5,1,0, 5,1, 5,0, 0,0);
        step("R3", 4,1,0, 4,1,1, 0,0, 4,4, 0,0);
        // R4: register zero
        step("R4", 0,1,0, 0,1,0, 0,1, 0,0, 0,0);
        step("R4", 0,1,1, 0,1,1, 0,0, 0,0, 0,0);
        // R5 / R7: load directly ahead, then one apart, then in mem2
        step("R5", 1,1,1, 0,0,0, 0,0, 1,2, 0,0);
        step("R7", 0,0,0, 1,1,1, 0,0, 1,2, 0,0);
        step("R5", 0,0,0, 0,0,0, 1,1, 1,2, 0,0);
        step("R5", 0,0,0, 6,1,1, 0,0, 3,6, 0,0);
        // R10: disabled or mismatched producers
        step("R10", 1,0,1, 1,0,0, 1,0, 1,1, 0,0);
        step("R10", 2,1,1, 3,1,0, 4,1, 1,5, 0,0);
        // R8: redirects
        step("R8", 1,1,0, 0,0,0, 0,0, 1,0, 1,0);
        step("R8", 0,0,0, 2,1,0, 0,0, 0,2, 0,1);
        // R9: redirect coincides with a load-use hazard
        step("R9", 7,1,1, 0,0,0, 0,0, 7,0, 1,0);
        step("R9", 0,0,0, 7,1,1, 0,0, 0,7, 0,1);
        // Random traffic over a small register space (R2 model compare)
        for (int i = 0; i < 400; i++) begin
            step("R2", int'($urandom_range(3)), bit'($urandom_range(1)), bit'($urandom_range(1)),
                       int'($urandom_range(3)), bit'($urandom_range(1)), bit'($urandom_range(1)),
                       int'($urandom_range(3)), bit'($urandom_range(1)),
                       int'($urandom_range(3)), int'($urandom_range(3)),
                       ($urandom_range(7) == 0), ($urandom_range(7) == 0));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule